// File: doc/BRIEF.md
# Status Output Pin Router

This block takes the internal status and data lines of a radio receiver and places any of them on four general-purpose output pins. Each pin has a 4-bit source select, an inversion bit and a receiver-running enable for each of up to four receiver configurations. The active configuration index picks which enable applies. A power-on input turns every pin's output enable on or off at once, so the pad ring can float the pins while the receiver is unpowered.

The configuration fields arrive as flat input vectors. They are captured into a register only on a clock edge where the load strobe is high, so the previous setting stays in force while new values are prepared. The path from a source signal to a pin is purely combinational, so clocks, strobes and data reach the pins without a register delay.

Top module: `outpin_router`

## Requirements
- R1: Pin p takes the source named by select field `cfg_sel_in[4p+3:4p]` as last loaded. The codes are 0 `sig_clk`, 1 `sig_rxrun`, 2 `sig_irq`, 3 constant 0, 4 constant 1, 5 `sig_data`, 6 `sig_mfdata`, 7 `sig_chdata`, 8 `sig_chstrobe`, 9 `sig_rxd` and 10 `sig_rxstrobe`.
- R2: Select codes 11 to 15 give a value of 0 before inversion.
- R3: On pin 3, code 0 (clock) gives 0 before inversion. The clock cannot reach that pin.
- R4: When a pin's inversion bit `cfg_inv_in[p]` is 1, its output is the complement of the selected value. Inversion applies after every other rule, including R2, R3 and R6.
- R5: While `pwr_on` is 0, every `pin_oe` bit is 0 and every `pin_val` bit is 0. While it is 1, every `pin_oe` bit is 1.
- R6: With code 1, pin p shows `sig_rxrun` AND enable bit `cfg_rren_in[4*cfg_idx+p]`. A cleared enable gives 0 before inversion.
- R7: After reset, pins 0 to 3 select codes 0, 1, 2 and 5, all inversion bits are 0, and all receiver-running enables are 1.
- R8: The configuration inputs take effect only after a rising clock edge with `cfg_load` high. Without that edge, changes on them have no effect on the pins.
- R9: A change on a selected source, or on `cfg_idx` or `pwr_on`, reaches the pins within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture strobe for the configuration inputs |
| cfg_sel_in | input | 16 | Four 4-bit select fields, pin p at bits 4p+3:4p |
| cfg_inv_in | input | 4 | Inversion bit per pin |
| cfg_rren_in | input | 16 | Receiver-running enables, bit 4c+p for configuration c and pin p |
| cfg_idx | input | 2 | Active configuration index |
| pwr_on | input | 1 | Power-on; low floats all pins |
| sig_clk | input | 1 | Clock-out source |
| sig_rxrun | input | 1 | Receiver-running source |
| sig_irq | input | 1 | Interrupt source |
| sig_data | input | 1 | Data source |
| sig_mfdata | input | 1 | Matched-filter data source |
| sig_chdata | input | 1 | Chip data source |
| sig_chstrobe | input | 1 | Chip strobe source |
| sig_rxd | input | 1 | Received data source |
| sig_rxstrobe | input | 1 | Received data strobe source |
| pin_val | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |

## Verification
The configuration register is the only state in the block, so a wrong stored field shows at the pins as soon as the matching source or select is used. A corrupted select or inversion bit shows at once as a wrong or complemented value on that pin. A wrong enable bit shows only when code 1 is selected under that configuration index. A load that comes a cycle early or late, or is missed, shows on the first sample after the capture edge. Sweeping every source pattern under every select code therefore exposes any fault within one pattern of its cause.

// File: rtl/pinrt_pkg.sv
package pinrt_pkg;
    localparam int NPIN  = 4;
    localparam int SELW  = 4;
    localparam int NCFG  = 4;
    localparam int CIDXW = $clog2(NCFG);
    localparam int NSRC  = 2 ** SELW;

    typedef enum logic [SELW-1:0] {
        SRC_CLK  = 4'd0,
        SRC_RUN  = 4'd1,
        SRC_IRQ  = 4'd2,
        SRC_LO   = 4'd3,
        SRC_HI   = 4'd4,
        SRC_DATA = 4'd5,
        SRC_MF   = 4'd6,
        SRC_CHD  = 4'd7,
        SRC_CHS  = 4'd8,
        SRC_RXD  = 4'd9,
        SRC_RXS  = 4'd10
    } src_e;

    typedef struct packed {
        logic [NPIN-1:0][SELW-1:0] sel;
        logic [NPIN-1:0]           inv;
        logic [NCFG-1:0][NPIN-1:0] rren;
    } pincfg_t;

    localparam pincfg_t CFG_RESET = '{
        sel:  {SELW'(SRC_DATA), SELW'(SRC_IRQ), SELW'(SRC_RUN), SELW'(SRC_CLK)},
        inv:  '0,
        rren: '1
    };
endpackage

// File: rtl/pinrt_cfg_regs.sv
module pinrt_cfg_regs
    import pinrt_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load_i,
    input  pincfg_t new_i,
    output pincfg_t cfg_o
);
    pincfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load_i) cfg_d = new_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(cfg_q));

    // R8
    cfg_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cfg_q == $past(new_i)));
endmodule

// File: rtl/pinrt_pin.sv
module pinrt_pin
    import pinrt_pkg::*;
#(
    parameter bit ALLOW_CLK = 1'b1
) (
    input  logic [NSRC-1:0] src_i,
    input  logic [SELW-1:0] sel_i,
    input  logic            inv_i,
    input  logic            run_en_i,
    input  logic            pwr_i,
    output logic            val_o,
    output logic            oe_o
);
    logic clk_ok;
    logic pick;

    generate
        if (ALLOW_CLK) begin : g_clk_on
            assign clk_ok = 1'b1;
        end else begin : g_clk_off
            assign clk_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        pick = src_i[sel_i];
        if (sel_i == SELW'(SRC_RUN)) pick = src_i[sel_i] & run_en_i;
        if ((sel_i == SELW'(SRC_CLK)) && !clk_ok) pick = 1'b0;
        val_o = pwr_i ? (pick ^ inv_i) : 1'b0;
        oe_o  = pwr_i;
    end
endmodule

// File: rtl/outpin_router.sv
module outpin_router
    import pinrt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_load,
    input  logic [NPIN*SELW-1:0] cfg_sel_in,
    input  logic [NPIN-1:0]      cfg_inv_in,
    input  logic [NCFG*NPIN-1:0] cfg_rren_in,
    input  logic [CIDXW-1:0]     cfg_idx,
    input  logic                 pwr_on,
    input  logic                 sig_clk,
    input  logic                 sig_rxrun,
    input  logic                 sig_irq,
    input  logic                 sig_data,
    input  logic                 sig_mfdata,
    input  logic                 sig_chdata,
    input  logic                 sig_chstrobe,
    input  logic                 sig_rxd,
    input  logic                 sig_rxstrobe,
    output logic [NPIN-1:0]      pin_val,
    output logic [NPIN-1:0]      pin_oe
);
    pincfg_t         new_cfg;
    pincfg_t         cfg;
    logic [NSRC-1:0] src_vec;

    always_comb begin
        new_cfg.sel  = cfg_sel_in;
        new_cfg.inv  = cfg_inv_in;
        new_cfg.rren = cfg_rren_in;
    end

    always_comb begin
        src_vec                = '0;
        src_vec[int'(SRC_CLK)]  = sig_clk;
        src_vec[int'(SRC_RUN)]  = sig_rxrun;
        src_vec[int'(SRC_IRQ)]  = sig_irq;
        src_vec[int'(SRC_LO)]   = 1'b0;
        src_vec[int'(SRC_HI)]   = 1'b1;
        src_vec[int'(SRC_DATA)] = sig_data;
        src_vec[int'(SRC_MF)]   = sig_mfdata;
        src_vec[int'(SRC_CHD)]  = sig_chdata;
        src_vec[int'(SRC_CHS)]  = sig_chstrobe;
        src_vec[int'(SRC_RXD)]  = sig_rxd;
        src_vec[int'(SRC_RXS)]  = sig_rxstrobe;
    end

    pinrt_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (cfg_load),
        .new_i  (new_cfg),
        .cfg_o  (cfg)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pinrt_pin #(.ALLOW_CLK(p != NPIN - 1)) u_pin (
            .src_i    (src_vec),
            .sel_i    (cfg.sel[p]),
            .inv_i    (cfg.inv[p]),
            .run_en_i (cfg.rren[cfg_idx][p]),
            .pwr_i    (pwr_on),
            .val_o    (pin_val[p]),
            .oe_o     (pin_oe[p])
        );

        // R2
        bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && (cfg.sel[p] > SELW'(SRC_RXS))) |-> (pin_val[p] == cfg.inv[p]));

        // R6
        run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && (cfg.sel[p] == SELW'(SRC_RUN)) && !cfg.rren[cfg_idx][p])
            |-> (pin_val[p] == cfg.inv[p]));

        // R4
        const_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && (cfg.sel[p] == SELW'(SRC_HI))) |-> (pin_val[p] == !cfg.inv[p]));
    end

    // R3
    last_noclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && (cfg.sel[NPIN-1] == SELW'(SRC_CLK)))
        |-> (pin_val[NPIN-1] == cfg.inv[NPIN-1]));

    // R5
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> ((pin_oe == '0) && (pin_val == '0)));

    // R5
    pwr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on |-> (pin_oe == '1));
endmodule

// File: tb/outpin_router_test.sv
`timescale 1ns/1ps
module outpin_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_sel_in = '0;
    logic [3:0]  cfg_inv_in = '0;
    logic [15:0] cfg_rren_in = '0;
    logic [1:0]  cfg_idx = '0;
    logic        pwr_on = 1'b1;
    logic [8:0]  s = '0;
    logic [3:0]  pin_val, pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    outpin_router uut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_sel_in(cfg_sel_in), .cfg_inv_in(cfg_inv_in),
        .cfg_rren_in(cfg_rren_in), .cfg_idx(cfg_idx), .pwr_on(pwr_on),
        .sig_clk(s[0]), .sig_rxrun(s[1]), .sig_irq(s[2]), .sig_data(s[3]),
        .sig_mfdata(s[4]), .sig_chdata(s[5]), .sig_chstrobe(s[6]),
        .sig_rxd(s[7]), .sig_rxstrobe(s[8]),
        .pin_val(pin_val), .pin_oe(pin_oe)
    );

    function automatic logic model(int code, int p, logic [8:0] src, logic inv,
                                   logic [15:0] mask, int idx, logic pwr);
        logic v;
        case (code)
            0:  v = (p == 3) ? 1'b0 : src[0];
            1:  v = src[1] & mask[idx*4 + p];
            2:  v = src[2];
            3:  v = 1'b0;
            4:  v = 1'b1;
            5, 6, 7, 8, 9, 10: v = src[code - 2];
            default: v = 1'b0;
        endcase
        return pwr ? (v ^ inv) : 1'b0;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic load(logic [15:0] sel, logic [3:0] inv, logic [15:0] mask);
        @(negedge clk);
        cfg_sel_in = sel; cfg_inv_in = inv; cfg_rren_in = mask; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic check_pins(logic [15:0] sel, logic [3:0] inv, logic [15:0] mask, string force_tag);
        for (int p = 0; p < 4; p++) begin
            int code;
            string tag;
            code = int'(sel[p*4 +: 4]);
            if (force_tag != "") tag = force_tag;
            else if (!pwr_on) tag = "R5";
            else if (code == 0 && p == 3) tag = "R3";
            else if (code >= 11) tag = "R2";
            else if (code == 1) tag = "R6";
            else if (inv[p]) tag = "R4";
            else tag = "R1";
            chk(tag, pin_val[p], model(code, p, s, inv[p], mask, int'(cfg_idx), pwr_on));
            chk("R5", pin_oe[p], pwr_on);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: defaults, driven with no load at all
        for (int pat = 0; pat < 512; pat++) begin
            @(negedge clk);
            s = 9'(pat); cfg_idx = 2'(pat % 4); pwr_on = 1'b1;
            #1;
            check_pins({4'd5, 4'd2, 4'd1, 4'd0}, 4'h0, 16'hFFFF, "R7");
        end

        // Main sweep: every code on every pin, two inversion patterns
        for (int code = 0; code < 16; code++) begin
            for (int iv = 0; iv < 2; iv++) begin
                logic [15:0] sel;
                logic [3:0]  inv;
                sel = {4{4'(code)}};
                inv = (iv == 0) ? 4'h6 : 4'h9;
                load(sel, inv, 16'hA5C3);
                for (int pat = 0; pat < 512; pat++) begin
                    @(negedge clk);
                    s = 9'(pat); cfg_idx = 2'(pat % 4); pwr_on = ((pat % 7) != 3);
                    #1;
                    check_pins(sel, inv, 16'hA5C3, "");
                end
            end
        end

        // R8: new inputs without a load strobe are ignored
        pwr_on = 1'b1;
        load({4{4'd5}}, 4'h0, 16'hFFFF);
        @(negedge clk);
        cfg_sel_in = {4{4'd4}}; cfg_inv_in = 4'hF; s = '0;
        repeat (2) @(negedge clk);
        #1;
        for (int p = 0; p < 4; p++) chk("R8", pin_val[p], 1'b0);
        @(negedge clk);
        cfg_load = 1'b1;
        #1;
        for (int p = 0; p < 4; p++) chk("R8", pin_val[p], 1'b0);
        @(negedge clk);
        cfg_load = 1'b0;
        #1;
        for (int p = 0; p < 4; p++) chk("R8", pin_val[p], 1'b0);
        cfg_inv_in = 4'h0;
        load({4{4'd4}}, 4'h0, 16'hFFFF);
        #1;
        for (int p = 0; p < 4; p++) chk("R8", pin_val[p], 1'b1);

        // R9: source and index changes show inside one half period
        load({4'd5, 4'd1, 4'd1, 4'd9}, 4'h0, 16'h0020);
        @(negedge clk);
        s = 9'b0_0000_1010; cfg_idx = 2'd1;
        #0.5;
        chk("R9", pin_val[3], 1'b1);
        chk("R9", pin_val[1], 1'b1);
        chk("R9", pin_val[2], 1'b0);
        s[3] = 1'b0; s[7] = 1'b1;
        #0.5;
        chk("R9", pin_val[3], 1'b0);
        chk("R9", pin_val[0], 1'b1);
        cfg_idx = 2'd0;
        #0.5;
        chk("R9", pin_val[1], 1'b0);
        pwr_on = 1'b0;
        #0.5;
        chk("R9", pin_oe[0], 1'b0);
        chk("R9", pin_val[0], 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule